// File: doc/BRIEF.md
# Operating-Point Step Sequencer

This controller moves one supply domain between four voltage/frequency operating points. Index 0 is 1.0 V at 2 GHz, index 1 is 0.9 V at 1.5 GHz, index 2 is 0.8 V at 1 GHz and index 3 is 0.7 V at 500 MHz. A lower index means higher performance. A request names a target index. The block then drives a voltage code to an external regulator and a divider select to the clock generator, and it orders the two steps so that the clock never runs faster than the present supply allows.

Each step is followed by a settle wait. The voltage wait is long (the default is 20000 cycles, about 100 µs at 200 MHz). The frequency wait is shorter (the default is 2000 cycles). A wait can end early on the regulator power-good input or the clock-lock input, but only after one eighth of its interval has passed. A request that arrives during a transition is kept in one pending slot. That slot is started as soon as the running transition completes.

The request port follows valid/ready rules, but it never applies back-pressure. `req_ready` is always high, and every beat with `req_valid` high is taken. When the slot already holds a request that has not started, the new beat overwrites it. No earlier request is queued.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, `cur_point` is 3, `volt_code` is code(3), `div_sel` is 3, and `busy` and `done` are low.
- R2: The voltage code for index i is `VC_TOP - VC_STEP*i` (defaults 100 and 10, in units of 10 mV). `div_sel` equals the index of the applied frequency. After a transition completes, both outputs match the target.
- R3: When the target index is lower than the current one, `volt_code` changes before `div_sel`.
- R4: When the target index is higher than the current one, `div_sel` changes before `volt_code`.
- R5: With the ready inputs held low, the voltage wait lasts exactly `VWAIT_CYC` cycles and the frequency wait exactly `FWAIT_CYC` cycles. `busy` is high for `VWAIT_CYC + FWAIT_CYC + 2` cycles per transition.
- R6: With the ready inputs high, a wait lasts `interval/8 + 1` cycles, so it never ends before the minimum dwell.
- R7: A request for the current point raises `done` without ever raising `busy`, and it changes neither output code.
- R8: A single pending slot holds requests that arrive while busy. A later request overwrites it, and it is launched right after `done`.
- R9: `volt_code` and `div_sel` never change in the same cycle.
- R10: `cur_point` changes only in a cycle where `done` is high. `done` and `busy` are never high together.
- R11: `req_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Always high; request accepted |
| req_point | input | IDX_W | Target operating-point index |
| vreg_good | input | 1 | Regulator power-good, ends voltage wait early |
| clk_locked | input | 1 | Clock lock, ends frequency wait early |
| volt_code | output | VC_W | Voltage code to regulator |
| div_sel | output | IDX_W | Divider select to clock generator |
| busy | output | 1 | Transition in progress |
| done | output | 1 | Request completed this cycle |
| cur_point | output | IDX_W | Operating point in effect |

## Verification
The hardest case to reach is the pending slot being overwritten while a long wait runs, followed by a launch straight out of the completion state. The bench requests a move and waits a few cycles. While the block is still busy it sends two more requests, then counts the `done` pulses and checks which point the block finally settles on. A further directed case holds both ready inputs high from the start. This shows that each wait ends at the minimum dwell rather than on the first cycle.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VOLT_STEP,
    ST_VOLT_WAIT,
    ST_FREQ_STEP,
    ST_FREQ_WAIT,
    ST_DONE
  } dvfs_state_e;
endpackage

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer #(
  parameter int LIM = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic rdy,
  output logic fin
);
  localparam int W = $clog2(LIM + 1);
  localparam logic [W-1:0] LAST = W'(LIM - 1);
  localparam logic [W-1:0] MIN_DWELL = W'(LIM / 8);

  logic [W-1:0] elapsed_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) elapsed_q <= '0;
    else if (run && elapsed_q != LAST) elapsed_q <= elapsed_q + 1'b1;
  end

  assign fin = run && ((elapsed_q == LAST) || (rdy && elapsed_q >= MIN_DWELL));
endmodule

// File: rtl/dvfs_req_slot.sv
module dvfs_req_slot #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             take,
  output logic             slot_v,
  output logic [IDX_W-1:0] slot_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v   <= 1'b0;
      slot_idx <= '0;
    end else if (wr) begin
      slot_v   <= 1'b1;
      slot_idx <= wr_idx;
    end else if (take) begin
      slot_v   <= 1'b0;
    end
  end
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int NUM_PTS   = 4,
  parameter int VC_W      = 8,
  parameter int VC_TOP    = 100,
  parameter int VC_STEP   = 10,
  parameter int VWAIT_CYC = 20000,
  parameter int FWAIT_CYC = 2000,
  localparam int IDX_W    = $clog2(NUM_PTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_point,
  input  logic             vreg_good,
  input  logic             clk_locked,
  output logic [VC_W-1:0]  volt_code,
  output logic [IDX_W-1:0] div_sel,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] cur_point
);
  localparam logic [IDX_W-1:0] RST_PT = IDX_W'(NUM_PTS - 1);

  function automatic logic [VC_W-1:0] code_of(input logic [IDX_W-1:0] idx);
    return VC_W'(VC_TOP - VC_STEP * int'(idx));
  endfunction

  dvfs_state_e state_q, state_d;
  logic [IDX_W-1:0] tgt_q, cur_q, div_q, slot_idx;
  logic [VC_W-1:0]  vcode_q;
  logic             up_q, slot_v, take, vfin, ffin, launch_ok;

  assign launch_ok = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign take      = launch_ok && slot_v;

  dvfs_req_slot #(.IDX_W(IDX_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .wr(req_valid), .wr_idx(req_point),
    .take(take), .slot_v(slot_v), .slot_idx(slot_idx)
  );

  dvfs_settle_timer #(.LIM(VWAIT_CYC)) u_vtimer (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_VOLT_STEP),
    .run(state_q == ST_VOLT_WAIT), .rdy(vreg_good), .fin(vfin)
  );

  dvfs_settle_timer #(.LIM(FWAIT_CYC)) u_ftimer (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_FREQ_STEP),
    .run(state_q == ST_FREQ_WAIT), .rdy(clk_locked), .fin(ffin)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (slot_v) begin
          if (slot_idx == cur_q)     state_d = ST_DONE;
          else if (slot_idx < cur_q) state_d = ST_VOLT_STEP;
          else                       state_d = ST_FREQ_STEP;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_VOLT_STEP: state_d = ST_VOLT_WAIT;
      ST_VOLT_WAIT: if (vfin) state_d = up_q ? ST_FREQ_STEP : ST_DONE;
      ST_FREQ_STEP: state_d = ST_FREQ_WAIT;
      ST_FREQ_WAIT: if (ffin) state_d = up_q ? ST_DONE : ST_VOLT_STEP;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= RST_PT;
      cur_q   <= RST_PT;
      div_q   <= RST_PT;
      vcode_q <= code_of(RST_PT);
      up_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        tgt_q <= slot_idx;
        up_q  <= slot_idx < cur_q;
      end
      if (state_q == ST_VOLT_STEP) vcode_q <= code_of(tgt_q);
      if (state_q == ST_FREQ_STEP) div_q   <= tgt_q;
      if (state_d == ST_DONE &&
          (state_q == ST_VOLT_WAIT || state_q == ST_FREQ_WAIT))
        cur_q <= tgt_q;
    end
  end

  assign req_ready = 1'b1;
  assign volt_code = vcode_q;
  assign div_sel   = div_q;
  assign cur_point = cur_q;
  assign done      = (state_q == ST_DONE);
  assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
endmodule

// File: rtl/dvfs_seq_checker.sv
module dvfs_seq_checker #(
  parameter int VC_W    = 8,
  parameter int VC_TOP  = 100,
  parameter int VC_STEP = 10,
  parameter int IDX_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [VC_W-1:0]  volt_code,
  input logic [IDX_W-1:0] div_sel,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] cur_point
);
  // R3 and R4: the supply always covers the applied clock
  assert_supply_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(volt_code) >= VC_TOP - VC_STEP * int'(div_sel));

  assert_no_joint_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(volt_code) && !$stable(div_sel)));

  assert_point_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_point) |-> done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_move_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(volt_code) || !$stable(div_sel)) |-> busy);

  assert_ready_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> req_ready);
endmodule

bind dvfs_seq dvfs_seq_checker #(
  .VC_W(VC_W), .VC_TOP(VC_TOP), .VC_STEP(VC_STEP), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .volt_code(volt_code),
  .div_sel(div_sel), .busy(busy), .done(done), .cur_point(cur_point)
);

// File: tb/dvfs_seq_bench.sv
module dvfs_seq_bench;
  localparam int VW = 64;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_point = '0;
  logic vreg_good = 1'b0;
  logic clk_locked = 1'b0;
  logic req_ready, busy, done;
  logic [7:0] volt_code;
  logic [1:0] div_sel, cur_point;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_n = 0, done_n = 0, vmove_n = 0, dmove_n = 0, joint_n = 0;
  int vmove_at = 0, dmove_at = 0, curmove_bad = 0;
  logic [7:0] v_prev;
  logic [1:0] d_prev, c_prev;

  always #2.5 clk = ~clk;

  dvfs_seq #(.VWAIT_CYC(VW), .FWAIT_CYC(FW)) u_dvfs_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_point(req_point), .vreg_good(vreg_good), .clk_locked(clk_locked),
    .volt_code(volt_code), .div_sel(div_sel), .busy(busy), .done(done),
    .cur_point(cur_point)
  );

  function automatic int code(input int i);
    return 100 - 10 * i;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy) busy_n++;
      if (done) done_n++;
      if (volt_code != v_prev) begin vmove_n++; vmove_at = cyc; end
      if (div_sel != d_prev) begin dmove_n++; dmove_at = cyc; end
      if (volt_code != v_prev && div_sel != d_prev) joint_n++;
      if (cur_point != c_prev && !done) curmove_bad++;
      if (req_ready !== 1'b1) curmove_bad++;
    end
    v_prev = volt_code;
    d_prev = div_sel;
    c_prev = cur_point;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clear_stats();
    busy_n = 0; done_n = 0; vmove_n = 0; dmove_n = 0;
    vmove_at = 0; dmove_at = 0;
  endtask

  task automatic send(input int idx);
    @(negedge clk);
    req_valid = 1'b1;
    req_point = 2'(idx);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_dones(input int n);
    int guard = 0;
    while (done_n < n && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cur_point == 2'd3, "R1 cur_point", cur_point, 3);
    chk(volt_code == 8'(code(3)), "R1 volt_code", volt_code, code(3));
    chk(div_sel == 2'd3, "R1 div_sel", div_sel, 3);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_same_point();
    clear_stats();
    send(3);
    wait_dones(1);
    chk(done_n == 1, "R7 done count", done_n, 1);
    chk(busy_n == 0, "R7 busy cycles", busy_n, 0);
    chk(vmove_n + dmove_n == 0, "R7 output moves", vmove_n + dmove_n, 0);
  endtask

  task automatic t_raise();
    vreg_good = 1'b0; clk_locked = 1'b0;
    clear_stats();
    send(0);
    wait_dones(1);
    chk(vmove_at != 0 && vmove_at < dmove_at, "R3 volt before div", vmove_at, dmove_at);
    chk(busy_n == VW + FW + 2, "R5 busy span raise", busy_n, VW + FW + 2);
    chk(volt_code == 8'(code(0)), "R2 volt_code 0", volt_code, code(0));
    chk(div_sel == 2'd0, "R2 div_sel 0", div_sel, 0);
    chk(cur_point == 2'd0, "R2 cur_point 0", cur_point, 0);
  endtask

  task automatic t_lower();
    clear_stats();
    send(2);
    wait_dones(1);
    chk(dmove_at != 0 && dmove_at < vmove_at, "R4 div before volt", dmove_at, vmove_at);
    chk(busy_n == VW + FW + 2, "R5 busy span lower", busy_n, VW + FW + 2);
    chk(volt_code == 8'(code(2)) && div_sel == 2'd2, "R2 outputs 2", volt_code, code(2));
  endtask

  task automatic t_early();
    vreg_good = 1'b1; clk_locked = 1'b1;
    clear_stats();
    send(1);
    wait_dones(1);
    chk(busy_n == (VW / 8 + 1) + (FW / 8 + 1) + 2, "R6 early exit span",
        busy_n, (VW / 8 + 1) + (FW / 8 + 1) + 2);
    chk(cur_point == 2'd1, "R6 cur_point 1", cur_point, 1);
    vreg_good = 1'b0; clk_locked = 1'b0;
  endtask

  task automatic t_pending();
    clear_stats();
    send(3);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R8 busy during move", busy, 1);
    send(0);
    send(2);
    wait_dones(2);
    chk(done_n == 2, "R8 done count", done_n, 2);
    chk(cur_point == 2'd2, "R8 final point", cur_point, 2);
    chk(volt_code == 8'(code(2)) && div_sel == 2'd2, "R8 final outputs", div_sel, 2);
  endtask

  initial begin
    v_prev = '0; d_prev = '0; c_prev = '0;
    t_reset();
    t_same_point();
    t_raise();
    t_lower();
    t_early();
    t_pending();
    chk(joint_n == 0, "R9 joint moves", joint_n, 0);
    chk(curmove_bad == 0, "R10 R11 point/ready rule", curmove_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule